// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for 9-bit words. It has a write side and a read side, and each side has its own clock. The two clocks may be the same net, or they may be unrelated. A word enters on a write-clock rising edge when both write enables are high. A word leaves on a read-clock rising edge when both read enables are high. The word that is read appears on a registered output.

Four status outputs describe how full the buffer is. Empty and almost-empty are computed in the read clock domain. Full and almost-full are computed in the write clock domain. Each almost flag compares against a threshold register. Both thresholds start at 7 after reset. They are reloaded through the write data port while a load input is held high.

An output enable decides whether the read data is presented. When it is low, the data bus reads as zero and a drive-enable output is low, which stands in for a released bus. An active-high asynchronous reset clears both pointers, both clock domains, the output register, the thresholds and the load sequence.

Top module: `dual_clock_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0, and `dout`=0 while `oe`=1.
- R2: A write takes place on a `wclk` rising edge only if `wen_a` and `wen_b` are both 1. With just one of them high, nothing is stored.
- R3: A read takes place on a `rclk` rising edge only if `ren_a` and `ren_b` are both 1. With just one of them high, `dout` and the stored count do not change.
- R4: Words come out in the order they were written. A read loads the oldest word into the `dout` register on the same `rclk` edge that performs the read.
- R5: `empty`=1 exactly when the stored count is 0. `full`=1 exactly when the stored count equals DEPTH.
- R6: With the default thresholds, `almost_empty`=1 exactly when the count is 7 or less. `almost_full`=1 exactly when DEPTH minus the count is 7 or less.
- R7: While `load`=1, each qualified write stores the low min(log2 DEPTH, 9) bits of `din` into a threshold register instead of the buffer. The first such write sets the empty threshold, the second sets the full threshold, and the third sets the empty threshold again, continuing in turn. With a threshold T, `almost_empty` = (count <= T) and `almost_full` = (DEPTH - count <= T).
- R8: With `oe`=0, `dout`=0 and `dout_en`=0. With `oe`=1, `dout_en`=1 and `dout` shows the read register.
- R9: A write attempted while `full`=1 is dropped. No stored word and no pointer changes.
- R10: A read attempted while `empty`=1 is ignored. `dout` and the read pointer keep their values.
- R11: Data order and the flags stay correct when `rclk` is slower than `wclk`, when it is faster, and when it is tied to `wclk`.
- R12: Reset puts both thresholds back to 7. It also restarts the load sequence, so the next load write goes to the empty threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high master reset for both domains |
| wclk | input | 1 | Write clock |
| wen_a | input | 1 | Write enable, first of the pair |
| wen_b | input | 1 | Write enable, second of the pair |
| load | input | 1 | When high, qualified writes go to the threshold registers |
| din | input | 9 | Write data or threshold value |
| rclk | input | 1 | Read clock |
| ren_a | input | 1 | Read enable, first of the pair |
| ren_b | input | 1 | Read enable, second of the pair |
| oe | input | 1 | Output enable |
| dout | output | 9 | Read data (zero when not enabled) |
| dout_en | output | 1 | High when the data bus is driven |
| empty | output | 1 | No words stored (read domain) |
| full | output | 1 | DEPTH words stored (write domain) |
| almost_empty | output | 1 | Count at or below the empty threshold (read domain) |
| almost_full | output | 1 | Free space at or below the full threshold (write domain) |

## Verification
The assertions are checked on every clock cycle. They cover these properties:
- The write pointer does not move unless both write enables are high, and it does not move during a load or while the buffer is full.
- The read pointer and the output register do not move while the buffer is empty.
- The Gray-coded write pointer changes at most one bit per edge.
- The output enable gates the data bus.
- Full always implies almost-full.

Three things cannot be shown by a single-cycle property, so the bench scenarios cover them:
- The exact flag thresholds at every fill level from 0 to DEPTH, with both default and loaded thresholds.
- The order of the threshold load sequence and its restart after reset.
- End-to-end data order across pointer wrap, with the read clock slower than, faster than and tied to the write clock.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int SYNC    = 2,
  parameter int DEF_OFF = 7
) (
  input  logic          rst,
  input  logic          wclk,
  input  logic          wen_a,
  input  logic          wen_b,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          ren_a,
  input  logic          ren_b,
  input  logic          oe,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int OW = (AW < DW) ? AW : DW;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dout_r;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s [SYNC];
  logic [PW-1:0] wg_s [SYNC];
  logic [OW-1:0] ae_off, af_off;
  logic          sel;
  logic [PW-1:0] wcount, rcount;

  wire wr_q   = wen_a & wen_b;
  wire push   = wr_q & ~load & ~full;
  wire wr_cfg = wr_q & load;
  wire pop    = ren_a & ren_b & ~empty;

  // write domain
  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + 1'b1;
      wgray <= b2g(wbin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      ae_off <= OW'(DEF_OFF);
      af_off <= OW'(DEF_OFF);
      sel    <= 1'b0;
    end else if (wr_cfg) begin
      if (sel) af_off <= din[OW-1:0];
      else     ae_off <= din[OW-1:0];
      sel <= ~sel;
    end
  end

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) rg_s[i] <= '0;
    end else begin
      rg_s[0] <= rgray;
      for (int i = 1; i < SYNC; i++) rg_s[i] <= rg_s[i-1];
    end
  end

  assign wcount      = wbin - g2b(rg_s[SYNC-1]);
  assign full        = (wcount == PW'(DEPTH));
  assign almost_full = ((PW'(DEPTH) - wcount) <= {{(PW-OW){1'b0}}, af_off});

  // read domain
  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      dout_r <= '0;
    end else if (pop) begin
      rbin   <= rbin + 1'b1;
      rgray  <= b2g(rbin + 1'b1);
      dout_r <= mem[rbin[AW-1:0]];
    end
  end

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) wg_s[i] <= '0;
    end else begin
      wg_s[0] <= wgray;
      for (int i = 1; i < SYNC; i++) wg_s[i] <= wg_s[i-1];
    end
  end

  assign rcount       = g2b(wg_s[SYNC-1]) - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= {{(PW-OW){1'b0}}, ae_off});

  assign dout    = oe ? dout_r : '0;
  assign dout_en = oe;

endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
  parameter int PW = 7,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wen_a,
  input logic          wen_b,
  input logic          load,
  input logic          ren_a,
  input logic          ren_b,
  input logic          oe,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rbin,
  input logic [DW-1:0] dout_r
);
  // R2
  wen_gate_chk: assert property (@(posedge wclk) disable iff (rst)
    !(wen_a && wen_b) |=> $stable(wbin));

  // R7
  load_nopush_chk: assert property (@(posedge wclk) disable iff (rst)
    (wen_a && wen_b && load) |=> $stable(wbin));

  // R9
  no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
    (full && wen_a && wen_b) |=> $stable(wbin));

  // R5
  full_af_chk: assert property (@(posedge wclk) disable iff (rst)
    full |-> almost_full);

  // R11
  wgray_step_chk: assert property (@(posedge wclk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  // R3
  ren_gate_chk: assert property (@(posedge rclk) disable iff (rst)
    !(ren_a && ren_b) |=> ($stable(rbin) && $stable(dout_r)));

  // R10
  no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
    empty |=> ($stable(rbin) && $stable(dout_r)));

  // R8
  oe_off_chk: assert property (@(posedge rclk) disable iff (rst)
    !oe |-> (dout == '0 && !dout_en));

  // R8
  oe_on_chk: assert property (@(posedge rclk) disable iff (rst)
    oe |-> (dout == dout_r && dout_en));
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.PW(PW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wen_a(wen_a), .wen_b(wen_b),
  .load(load), .ren_a(ren_a), .ren_b(ren_b), .oe(oe), .dout(dout),
  .dout_en(dout_en), .full(full), .almost_full(almost_full), .empty(empty),
  .wbin(wbin), .wgray(wgray), .rbin(rbin), .dout_r(dout_r)
);

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  localparam int DEPTH = 64;

  logic wclk = 0, aclk = 0, async_m = 0;
  real  ahalf = 7.0;
  wire  rclk = async_m ? aclk : wclk;
  always #4 wclk = ~wclk;
  always #(ahalf) aclk = ~aclk;

  logic       rst = 1, wen_a = 0, wen_b = 0, load = 0, ren_a = 0, ren_b = 0, oe = 1;
  logic [8:0] din = 0;
  logic [8:0] dout;
  logic       dout_en, empty, full, almost_empty, almost_full;
  int errors = 0, checks = 0;

  dual_clock_fifo i_dual_clock_fifo (
    .rst(rst), .wclk(wclk), .wen_a(wen_a), .wen_b(wen_b), .load(load), .din(din),
    .rclk(rclk), .ren_a(ren_a), .ren_b(ren_b), .oe(oe), .dout(dout), .dout_en(dout_en),
    .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full));

  function automatic logic [8:0] pat(int k);
    return 9'((k * 37 + 5) % 512);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic settle();
    repeat (5) @(posedge wclk);
    repeat (5) @(posedge rclk);
    #1;
  endtask

  task automatic wr(logic a, logic b, logic [8:0] d);
    @(negedge wclk); wen_a = a; wen_b = b; din = d;
    @(negedge wclk); wen_a = 0; wen_b = 0;
  endtask

  task automatic rd(logic a, logic b);
    @(negedge rclk); ren_a = a; ren_b = b;
    @(negedge rclk); ren_a = 0; ren_b = 0;
  endtask

  task automatic chk_flags(int c, int aeo, int afo, string req);
    chk(req, "empty", int'(empty), int'(c == 0));
    chk(req, "full", int'(full), int'(c == DEPTH));
    chk(req, "almost_empty", int'(almost_empty), int'(c <= aeo));
    chk(req, "almost_full", int'(almost_full), int'((DEPTH - c) <= afo));
  endtask

  task automatic do_reset();
    rst = 1; wen_a = 0; wen_b = 0; ren_a = 0; ren_b = 0; load = 0;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    @(negedge wclk); rst = 0;
    settle();
  endtask

  task automatic load_off(logic [8:0] v);
    @(negedge wclk); load = 1;
    wr(1, 1, v);
    load = 0;
  endtask

  task automatic fill(int n, int base);
    for (int k = 0; k < n; k++) wr(1, 1, pat(base + k));
    settle();
  endtask

  task automatic drain(int n, int base, string req);
    for (int k = 0; k < n; k++) begin
      rd(1, 1);
      chk(req, "dout", int'(dout), int'(pat(base + k)));
    end
    settle();
  endtask

  task automatic sweep(int base, int aeo, int afo, string req);
    for (int c = 0; c <= DEPTH; c++) begin
      settle();
      chk_flags(c, aeo, afo, req);
      if (c < DEPTH) wr(1, 1, pat(base + c));
    end
    // R9: write while full is dropped
    wr(1, 1, 9'h1AA);
    settle();
    chk_flags(DEPTH, aeo, afo, "R9");
    for (int c = DEPTH; c > 0; c--) begin
      rd(1, 1);
      chk("R4", "order", int'(dout), int'(pat(base + DEPTH - c)));
      settle();
      chk_flags(c - 1, aeo, afo, req);
    end
  endtask

  task automatic stream(int n, int base);
    fork
      begin
        int sent = 0;
        while (sent < n) begin
          @(negedge wclk);
          if (!full) begin wen_a = 1; wen_b = 1; din = pat(base + sent); sent++; end
          else begin wen_a = 0; wen_b = 0; end
        end
        @(negedge wclk); wen_a = 0; wen_b = 0;
      end
      begin
        int  got = 0;
        logic pend = 0;
        while (got < n) begin
          @(negedge rclk);
          if (pend) begin
            chk("R11", "stream", int'(dout), int'(pat(base + got)));
            got++;
          end
          if (got < n && !empty) begin ren_a = 1; ren_b = 1; pend = 1; end
          else begin ren_a = 0; ren_b = 0; pend = 0; end
        end
        ren_a = 0; ren_b = 0;
      end
    join
    settle();
    chk_flags(0, 7, 7, "R11");
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    chk_flags(0, 7, 7, "R1");
    chk("R1", "dout", int'(dout), 0);
    chk("R8", "dout_en on", int'(dout_en), 1);
    oe = 0; #1;
    chk("R8", "dout_en off", int'(dout_en), 0);
    oe = 1;

    // R2: one enable only
    wr(1, 0, 9'h011); wr(0, 1, 9'h022);
    settle();
    chk("R2", "empty", int'(empty), 1);

    // R10: read while empty
    rd(1, 1);
    chk("R10", "dout", int'(dout), 0);
    settle();
    chk("R10", "empty", int'(empty), 1);

    // R6/R5 sweep with default thresholds, single clock
    sweep(0, 7, 7, "R6");

    // R3: partial read enables do nothing
    fill(3, 500);
    rd(1, 0); rd(0, 1);
    chk("R3", "dout", int'(dout), int'(pat(DEPTH - 1)));
    settle();
    chk_flags(3, 7, 7, "R3");
    rd(1, 1);
    chk("R4", "first", int'(dout), int'(pat(500)));
    oe = 0; #1;
    chk("R8", "dout zero", int'(dout), 0);
    oe = 1; #1;
    chk("R8", "dout shown", int'(dout), int'(pat(500)));
    drain(2, 501, "R4");

    // R7: load sequence, not pushed
    load_off(9'd20);
    load_off(9'd10);
    @(negedge wclk); load = 1;
    wr(0, 1, 9'd33);
    load = 0;
    settle();
    chk("R7", "empty", int'(empty), 1);
    sweep(300, 20, 10, "R7");
    load_off(9'd30);
    fill(30, 700);
    chk("R7", "ae at 30", int'(almost_empty), 1);
    fill(1, 730);
    chk("R7", "ae at 31", int'(almost_empty), 0);
    chk("R7", "af at 31", int'(almost_full), 0);
    drain(31, 700, "R7");

    // R12: reset restores defaults and sequence, async read clock
    async_m = 1;
    do_reset();
    chk_flags(0, 7, 7, "R12");
    fill(8, 900);
    chk("R12", "ae at 8", int'(almost_empty), 0);
    load_off(9'd12);
    settle();
    chk("R12", "ae reload", int'(almost_empty), 1);
    fill(5, 908);
    chk("R12", "ae at 13", int'(almost_empty), 0);
    fill(43, 913);
    chk("R12", "af at 56", int'(almost_full), 0);
    fill(1, 956);
    chk("R12", "af at 57", int'(almost_full), 1);
    drain(57, 900, "R12");
    chk_flags(0, 12, 7, "R12");

    // R11: slow then fast read clock
    stream(150, 1000);
    ahalf = 2.5;
    settle();
    stream(150, 2000);
    report();
  end
endmodule